// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block holds a small set of list entries that feed a virtual CPU interrupt interface. Host software programs each entry through a write port with a virtual interrupt number, a pending flag, an active flag, a hardware-link flag and a physical interrupt number. The guest then acknowledges interrupts, which returns the virtual number of a pending entry and marks it active. It later signals end-of-interrupt with a virtual number, which retires the matching active entry.

When a retired entry carries the hardware-link flag, the block sends a single-cycle deactivate request, carrying that entry's physical number, towards the physical distributor. The host never has to touch the physical interrupt itself. Linked entries may be pending or active, but never both at once. A host write that asks for both on a linked entry is refused and raises a sticky error flag.

Each entry also presents an empty flag and a four-bit status nibble, so host software can see which entries are free.

Top module: `irq_list_bank`

## Requirements
- R1: After reset every entry is inactive and unlinked. All empty flags read 1, all status nibbles read 0, the acknowledge value is the spurious code (all ones, 1023 at the default width), the deactivate request is low, and both error flags are low.
- R2: An accepted host write replaces the addressed entry at the next clock edge. The status nibble of entry i sits at bits 4i+3..4i and has pending at bit 0, active at bit 1, 0 at bit 2 and link at bit 3. So linked-inactive reads 8, linked-pending 9 and linked-active 10. The entry's empty flag reads 1 exactly when both pending and active are 0.
- R3: The acknowledge value is the virtual number of the lowest-index pending entry. An acknowledge request clears that entry's pending flag and sets its active flag at the next edge.
- R4: With no pending entry, the acknowledge value is the spurious code, and an acknowledge request changes no entry.
- R5: An end-of-interrupt request clears the active flag of the lowest-index active entry whose virtual number matches. An unlinked entry that was both pending and active stays pending, so its nibble reads 1.
- R6: An end-of-interrupt that retires a linked entry raises the deactivate request in the following cycle only, with that entry's physical number on the physical-number output.
- R7: An end-of-interrupt that retires an unlinked entry leaves the deactivate request low.
- R8: A host write with link, pending and active all set is refused. The entry keeps its previous contents, and the bad-write flag goes to 1 and stays there until reset.
- R9: An end-of-interrupt whose number matches no active entry changes no entry and raises no deactivate request. The stray-end flag goes to 1 and stays there until reset.
- R10: When an accepted host write and a guest acknowledge or end-of-interrupt select the same entry in the same cycle, the entry takes the written contents and no deactivate request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrIdx | input | IDX_W | Entry selected by the host write |
| hostWrVid | input | VID_W | Virtual number to store |
| hostWrPend | input | 1 | Pending flag to store |
| hostWrAct | input | 1 | Active flag to store |
| hostWrLink | input | 1 | Hardware-link flag to store |
| hostWrPid | input | PID_W | Physical number to store |
| ackReq | input | 1 | Guest acknowledge request |
| ackVid | output | VID_W | Acknowledge value: lowest pending virtual number, or the spurious code |
| eoiReq | input | 1 | Guest end-of-interrupt request |
| eoiVid | input | VID_W | Virtual number being retired |
| deactValid | output | 1 | Single-cycle deactivate request to the distributor |
| deactPid | output | PID_W | Physical number of the deactivate request |
| emptyBits | output | NUM_ENTRIES | Per-entry empty flags |
| statusNib | output | 4*NUM_ENTRIES | Per-entry status nibbles |
| badWrite | output | 1 | Sticky flag for a refused host write |
| strayEoi | output | 1 | Sticky flag for an unmatched end-of-interrupt |

## Verification
The bench builds the block with its defaults: four entries and 10-bit virtual and physical numbers, which makes the spurious code 1023. Four entries are enough to hold, at the same time, a linked entry that produces a deactivate pulse, an unlinked pending-and-active entry that falls back to pending, a refused linked write and an unmatched end-of-interrupt. They also leave a spare entry for the host-versus-guest collision case. The 10-bit numbers make the spurious code distinct from every programmed number, and they let the physical numbers differ from the virtual ones, so a swapped field shows up.

// File: rtl/irq_list_pkg.sv
package irq_list_pkg;

  // Bit positions inside a per-entry status nibble
  localparam int NIB_PEND = 0;
  localparam int NIB_ACT  = 1;
  localparam int NIB_LINK = 3;

  // Strobes from the control to the entry storage
  typedef struct packed {
    logic wrGo;   // accepted host write to wrIdx
    logic ackGo;  // acknowledge applies to ackIdx
    logic eoiGo;  // end-of-interrupt applies to eoiIdx
  } lrCmd_t;

endpackage

// File: rtl/irq_list_ctrl.sv
module irq_list_ctrl
  import irq_list_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W       = 10,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                hostWrEn,
  input  logic [IDX_W-1:0]                    hostWrIdx,
  input  logic                                hostWrPend,
  input  logic                                hostWrAct,
  input  logic                                hostWrLink,
  input  logic                                ackReq,
  input  logic                                eoiReq,
  input  logic [VID_W-1:0]                    eoiVid,
  input  logic [NUM_ENTRIES-1:0]              pendVec,
  input  logic [NUM_ENTRIES-1:0]              actVec,
  input  logic [NUM_ENTRIES-1:0][VID_W-1:0]   vidArr,
  output lrCmd_t                              cmd,
  output logic [IDX_W-1:0]                    ackIdx,
  output logic [IDX_W-1:0]                    eoiIdx,
  output logic [VID_W-1:0]                    ackVid,
  output logic                                badWrite,
  output logic                                strayEoi
);

  localparam logic [VID_W-1:0] SPURIOUS = '1;

  logic ackFound, eoiFound, wrOk, wrBad, eoiMiss;

  // Lowest-index pending entry for an acknowledge
  always_comb begin
    ackFound = 1'b0;
    ackIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        ackFound = 1'b1;
        ackIdx   = IDX_W'(i);
      end
    end
  end

  // Lowest-index active entry whose number matches the retired one
  always_comb begin
    eoiFound = 1'b0;
    eoiIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (actVec[i] && (vidArr[i] == eoiVid)) begin
        eoiFound = 1'b1;
        eoiIdx   = IDX_W'(i);
      end
    end
  end

  assign ackVid  = ackFound ? vidArr[ackIdx] : SPURIOUS;

  // Linked entries may not be pending and active together
  assign wrBad   = hostWrEn & hostWrLink & hostWrPend & hostWrAct;
  assign wrOk    = hostWrEn & ~wrBad;
  assign eoiMiss = eoiReq & ~eoiFound;

  // An accepted host write wins over guest actions on the same entry
  always_comb begin
    cmd.wrGo  = wrOk;
    cmd.ackGo = ackReq & ackFound & ~(wrOk & (hostWrIdx == ackIdx));
    cmd.eoiGo = eoiReq & eoiFound & ~(wrOk & (hostWrIdx == eoiIdx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badWrite <= 1'b0;
      strayEoi <= 1'b0;
    end else begin
      if (wrBad)   badWrite <= 1'b1;
      if (eoiMiss) strayEoi <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_list_store.sv
module irq_list_store
  import irq_list_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W       = 10,
  parameter int PID_W       = 10,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  lrCmd_t                              cmd,
  input  logic [IDX_W-1:0]                    wrIdx,
  input  logic [VID_W-1:0]                    wrVid,
  input  logic                                wrPend,
  input  logic                                wrAct,
  input  logic                                wrLink,
  input  logic [PID_W-1:0]                    wrPid,
  input  logic [IDX_W-1:0]                    ackIdx,
  input  logic [IDX_W-1:0]                    eoiIdx,
  output logic [NUM_ENTRIES-1:0]              pendVec,
  output logic [NUM_ENTRIES-1:0]              actVec,
  output logic [NUM_ENTRIES-1:0][VID_W-1:0]   vidArr,
  output logic                                deactValid,
  output logic [PID_W-1:0]                    deactPid,
  output logic [NUM_ENTRIES-1:0]              emptyBits,
  output logic [4*NUM_ENTRIES-1:0]            statusNib
);

  logic [NUM_ENTRIES-1:0]             linkVec;
  logic [NUM_ENTRIES-1:0][PID_W-1:0]  pidArr;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [VID_W-1:0] vidR;
    logic [PID_W-1:0] pidR;
    logic             pendR, actR, linkR;
    logic             wrHere, ackHere, eoiHere;

    assign wrHere  = cmd.wrGo  && (wrIdx  == IDX_W'(i));
    assign ackHere = cmd.ackGo && (ackIdx == IDX_W'(i));
    assign eoiHere = cmd.eoiGo && (eoiIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vidR  <= '0;
        pidR  <= '0;
        pendR <= 1'b0;
        actR  <= 1'b0;
        linkR <= 1'b0;
      end else if (wrHere) begin
        vidR  <= wrVid;
        pidR  <= wrPid;
        pendR <= wrPend;
        actR  <= wrAct;
        linkR <= wrLink;
      end else begin
        if (ackHere) begin
          pendR <= 1'b0;
          actR  <= 1'b1;
        end
        if (eoiHere) actR <= 1'b0;
      end
    end

    assign pendVec[i] = pendR;
    assign actVec[i]  = actR;
    assign linkVec[i] = linkR;
    assign vidArr[i]  = vidR;
    assign pidArr[i]  = pidR;
    assign emptyBits[i] = ~(pendR | actR);
    assign statusNib[4*i+NIB_PEND] = pendR;
    assign statusNib[4*i+NIB_ACT]  = actR;
    assign statusNib[4*i+2]        = 1'b0;
    assign statusNib[4*i+NIB_LINK] = linkR;
  end

  // Deactivate request issued the cycle after a linked entry retires
  logic linkRetire;
  assign linkRetire = cmd.eoiGo & linkVec[eoiIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deactValid <= 1'b0;
      deactPid   <= '0;
    end else begin
      deactValid <= linkRetire;
      if (linkRetire) deactPid <= pidArr[eoiIdx];
    end
  end

endmodule

// File: rtl/irq_list_bank.sv
module irq_list_bank
  import irq_list_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W       = 10,
  parameter int PID_W       = 10,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostWrEn,
  input  logic [IDX_W-1:0]            hostWrIdx,
  input  logic [VID_W-1:0]            hostWrVid,
  input  logic                        hostWrPend,
  input  logic                        hostWrAct,
  input  logic                        hostWrLink,
  input  logic [PID_W-1:0]            hostWrPid,
  input  logic                        ackReq,
  output logic [VID_W-1:0]            ackVid,
  input  logic                        eoiReq,
  input  logic [VID_W-1:0]            eoiVid,
  output logic                        deactValid,
  output logic [PID_W-1:0]            deactPid,
  output logic [NUM_ENTRIES-1:0]      emptyBits,
  output logic [4*NUM_ENTRIES-1:0]    statusNib,
  output logic                        badWrite,
  output logic                        strayEoi
);

  lrCmd_t                             cmd;
  logic [IDX_W-1:0]                   ackIdx, eoiIdx;
  logic [NUM_ENTRIES-1:0]             pendVec, actVec;
  logic [NUM_ENTRIES-1:0][VID_W-1:0]  vidArr;

  irq_list_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .VID_W(VID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx), .hostWrPend(hostWrPend),
    .hostWrAct(hostWrAct), .hostWrLink(hostWrLink),
    .ackReq(ackReq), .eoiReq(eoiReq), .eoiVid(eoiVid),
    .pendVec(pendVec), .actVec(actVec), .vidArr(vidArr),
    .cmd(cmd), .ackIdx(ackIdx), .eoiIdx(eoiIdx), .ackVid(ackVid),
    .badWrite(badWrite), .strayEoi(strayEoi)
  );

  irq_list_store #(.NUM_ENTRIES(NUM_ENTRIES), .VID_W(VID_W), .PID_W(PID_W)) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .wrIdx(hostWrIdx), .wrVid(hostWrVid), .wrPend(hostWrPend),
    .wrAct(hostWrAct), .wrLink(hostWrLink), .wrPid(hostWrPid),
    .ackIdx(ackIdx), .eoiIdx(eoiIdx),
    .pendVec(pendVec), .actVec(actVec), .vidArr(vidArr),
    .deactValid(deactValid), .deactPid(deactPid),
    .emptyBits(emptyBits), .statusNib(statusNib)
  );

endmodule

// File: rtl/irq_list_bank_chk.sv
module irq_list_bank_chk #(
  parameter int NUM_ENTRIES = 4,
  parameter int VID_W       = 10,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      hostWrEn,
  input logic [IDX_W-1:0]          hostWrIdx,
  input logic                      hostWrPend,
  input logic                      hostWrAct,
  input logic                      hostWrLink,
  input logic [VID_W-1:0]          ackVid,
  input logic                      eoiReq,
  input logic                      deactValid,
  input logic [4*NUM_ENTRIES-1:0]  statusNib,
  input logic                      badWrite,
  input logic                      strayEoi
);

  logic anyPend;
  always_comb begin
    anyPend = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) anyPend = anyPend | statusNib[4*i];
  end

  // R4: nothing pending means the spurious code
  p_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    !anyPend |-> (ackVid == {VID_W{1'b1}}));

  // R6: a deactivate request only follows an end-of-interrupt
  p_deact_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    deactValid |-> $past(eoiReq));

  // R8: refused write raises the flag, which then holds
  p_bad_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostWrLink && hostWrPend && hostWrAct) |=> badWrite);

  p_bad_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> badWrite);

  // R9: stray-end flag holds once set
  p_stray_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    strayEoi |=> strayEoi);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
    // R8: a linked entry never reads pending and active together
    p_link_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
      !(statusNib[4*i+3] && statusNib[4*i+1] && statusNib[4*i]));

    // R2 / R10: an accepted write lands in the nibble at the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
      (hostWrEn && (hostWrIdx == IDX_W'(i)) && !(hostWrLink && hostWrPend && hostWrAct))
      |=> (statusNib[4*i +: 4] == {$past(hostWrLink), 1'b0, $past(hostWrAct), $past(hostWrPend)}));
  end

endmodule

bind irq_list_bank irq_list_bank_chk #(.NUM_ENTRIES(NUM_ENTRIES), .VID_W(VID_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx),
  .hostWrPend(hostWrPend), .hostWrAct(hostWrAct), .hostWrLink(hostWrLink),
  .ackVid(ackVid), .eoiReq(eoiReq), .deactValid(deactValid),
  .statusNib(statusNib), .badWrite(badWrite), .strayEoi(strayEoi)
);

// File: tb/irq_list_bank_test.sv
module irq_list_bank_test;

  localparam int N = 4;
  localparam int VW = 10;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWrEn = 1'b0;
  logic [1:0]    hostWrIdx = '0;
  logic [VW-1:0] hostWrVid = '0;
  logic          hostWrPend = 1'b0, hostWrAct = 1'b0, hostWrLink = 1'b0;
  logic [PW-1:0] hostWrPid = '0;
  logic          ackReq = 1'b0;
  logic [VW-1:0] ackVid;
  logic          eoiReq = 1'b0;
  logic [VW-1:0] eoiVid = '0;
  logic          deactValid;
  logic [PW-1:0] deactPid;
  logic [N-1:0]  emptyBits;
  logic [4*N-1:0] statusNib;
  logic          badWrite, strayEoi;

  irq_list_bank #(.NUM_ENTRIES(N), .VID_W(VW), .PID_W(PW)) uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx),
    .hostWrVid(hostWrVid), .hostWrPend(hostWrPend), .hostWrAct(hostWrAct),
    .hostWrLink(hostWrLink), .hostWrPid(hostWrPid), .ackReq(ackReq),
    .ackVid(ackVid), .eoiReq(eoiReq), .eoiVid(eoiVid),
    .deactValid(deactValid), .deactPid(deactPid), .emptyBits(emptyBits),
    .statusNib(statusNib), .badWrite(badWrite), .strayEoi(strayEoi)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  localparam logic [1:0] OP_WR = 2'd0, OP_ACK = 2'd1, OP_EOI = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  idx;
    logic [9:0]  vid;
    logic        pend;
    logic        act;
    logic        link;
    logic [9:0]  pid;
    logic [1:0]  chk;
    logic [3:0]  expNib;
    logic [9:0]  expAck;
    logic        expDv;
    logic [9:0]  expDp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,  2'd0, 10'd35, 1'b1, 1'b0, 1'b0, 10'd0,   2'd0, 4'd1,  10'd0,    1'b0, 10'd0,  4'd2}, // R2 unlinked pending
    '{OP_WR,  2'd1, 10'd27, 1'b1, 1'b0, 1'b1, 10'd99,  2'd1, 4'd9,  10'd0,    1'b0, 10'd0,  4'd2}, // R2 linked pending
    '{OP_WR,  2'd2, 10'd40, 1'b1, 1'b1, 1'b0, 10'd0,   2'd2, 4'd3,  10'd0,    1'b0, 10'd0,  4'd2}, // R2 unlinked both
    '{OP_ACK, 2'd0, 10'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0, 4'd2,  10'd35,   1'b0, 10'd0,  4'd3}, // R3 lowest first
    '{OP_ACK, 2'd0, 10'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd1, 4'd10, 10'd27,   1'b0, 10'd0,  4'd3}, // R3 linked active
    '{OP_ACK, 2'd0, 10'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd2, 4'd2,  10'd40,   1'b0, 10'd0,  4'd3}, // R3 both -> active
    '{OP_ACK, 2'd0, 10'd0,  1'b0, 1'b0, 1'b0, 10'd0,   2'd0, 4'd2,  10'd1023, 1'b0, 10'd0,  4'd4}, // R4 spurious
    '{OP_EOI, 2'd0, 10'd27, 1'b0, 1'b0, 1'b0, 10'd0,   2'd1, 4'd8,  10'd0,    1'b1, 10'd99, 4'd6}, // R6 linked retire
    '{OP_EOI, 2'd0, 10'd35, 1'b0, 1'b0, 1'b0, 10'd0,   2'd0, 4'd0,  10'd0,    1'b0, 10'd0,  4'd7}, // R7 no pulse
    '{OP_EOI, 2'd0, 10'd77, 1'b0, 1'b0, 1'b0, 10'd0,   2'd2, 4'd2,  10'd0,    1'b0, 10'd0,  4'd9}, // R9 stray
    '{OP_WR,  2'd3, 10'd50, 1'b1, 1'b1, 1'b1, 10'd5,   2'd3, 4'd0,  10'd0,    1'b0, 10'd0,  4'd8}, // R8 refused
    '{OP_WR,  2'd2, 10'd40, 1'b1, 1'b1, 1'b0, 10'd0,   2'd2, 4'd3,  10'd0,    1'b0, 10'd0,  4'd2}, // R2 rewrite both
    '{OP_EOI, 2'd0, 10'd40, 1'b0, 1'b0, 1'b0, 10'd0,   2'd2, 4'd1,  10'd0,    1'b0, 10'd0,  4'd5}, // R5 pending kept
    '{OP_WR,  2'd3, 10'd60, 1'b0, 1'b1, 1'b1, 10'd300, 2'd3, 4'd10, 10'd0,    1'b0, 10'd0,  4'd2}  // R2 linked active
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1", "empty", int'(emptyBits), 15);
    check("R1", "nibbles", int'(statusNib), 0);
    check("R1", "ackVid", int'(ackVid), 1023);
    check("R1", "deactValid", int'(deactValid), 0);
    check("R1", "flags", int'({badWrite, strayEoi}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "empty after release", int'(emptyBits), 15);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      hostWrEn   = (VECS[v].op == OP_WR);
      hostWrIdx  = VECS[v].idx;
      hostWrVid  = VECS[v].vid;
      hostWrPend = VECS[v].pend;
      hostWrAct  = VECS[v].act;
      hostWrLink = VECS[v].link;
      hostWrPid  = VECS[v].pid;
      ackReq     = (VECS[v].op == OP_ACK);
      eoiReq     = (VECS[v].op == OP_EOI);
      eoiVid     = VECS[v].vid;
      #1;
      if (VECS[v].op == OP_ACK) check(tag, "ackVid", int'(ackVid), int'(VECS[v].expAck));
      @(posedge clk);
      @(negedge clk);
      hostWrEn = 1'b0; ackReq = 1'b0; eoiReq = 1'b0;
      check(tag, "nibble", int'(statusNib[4*VECS[v].chk +: 4]), int'(VECS[v].expNib));
      check(tag, "deactValid", int'(deactValid), int'(VECS[v].expDv));
      if (VECS[v].expDv) check(tag, "deactPid", int'(deactPid), int'(VECS[v].expDp));
    end

    // Sticky flags and empty flags after the table
    check("R8", "badWrite sticky", int'(badWrite), 1);
    check("R9", "strayEoi sticky", int'(strayEoi), 1);
    check("R2", "emptyBits", int'(emptyBits), 3);

    // R10: host write and end-of-interrupt hit linked entry 3 together
    hostWrEn = 1'b1; hostWrIdx = 2'd3; hostWrVid = 10'd61;
    hostWrPend = 1'b1; hostWrAct = 1'b0; hostWrLink = 1'b0; hostWrPid = 10'd0;
    eoiReq = 1'b1; eoiVid = 10'd60;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0; eoiReq = 1'b0;
    check("R10", "collision nibble", int'(statusNib[12 +: 4]), 1);
    check("R10", "collision deactValid", int'(deactValid), 0);
    #1;
    check("R3", "ackVid after collision", int'(ackVid), 40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule